// File: doc/BRIEF.md
# Byte ALU with Masked Condition Flags

This block is the arithmetic core of a small byte-wide processor datapath. Two operands and a three-bit operation code go in. A combinational result and a result-write strobe come out. Four condition flags are held in a register: negative, zero, overflow and carry/borrow. Each operation carries its own flag policy. A flag is either recomputed from the operation, forced to zero, or kept at its stored value. The register captures the merged flag set on a clock edge only while the flag-write enable is high.

The sequencer around the block picks the operation, presents the operands, and writes `result` back to its accumulator when `result_we` is high. The test and hold codes assert no result write, so the accumulator is left alone. Subtraction and negation report a borrow in the carry flag, not a carry-out.

Top module: `alu8_nzvc`

## Requirements
- R1: For every operation code except hold (7), a flag write sets N to bit 7 of `result` and sets Z only when all eight bits of `result` are zero.
- R2: Add (code 0) gives `result` = (A + B) mod 256 and sets C when the unsigned sum exceeds 255.
- R3: Add sets V only when A and B have the same sign bit and the result's sign bit differs from it.
- R4: Subtract (code 1) gives `result` = (A - B) mod 256 and sets C when B, taken as unsigned, is greater than A.
- R5: Subtract sets V only when A and B differ in sign and the result's sign differs from A's sign.
- R6: Negate (code 2) gives `result` = (0 - A) mod 256 and applies the subtract flag rules: C is set for any nonzero A, and V is set only for A = 0x80.
- R7: Arithmetic shift right (code 3) gives `result` = {A[7], A[7:1]}, sets C to A[0], and sets V to N XOR C.
- R8: Clear (code 4) gives `result` = 0 and, on a flag write, N=0, Z=1, V=0, C=0.
- R9: Load (code 5) gives `result` = A, updates N and Z from A, forces V to 0 and keeps C at its stored value.
- R10: Test (code 6) sets the flags from A - 0 (N and Z from A, V=0, C=0) and holds `result_we` low. All other codes except hold drive `result_we` high.
- R11: Hold (code 7) leaves all four flags unchanged even with the flag write enabled, and holds `result_we` low.
- R12: The flags change only on a rising clock edge with `flag_we` high. A synchronous active-low reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| flag_we | input | 1 | Flag register write enable |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 negate, 3 shift right, 4 clear, 5 load, 6 test, 7 hold |
| opnd_a | input | 8 | First operand (minuend, shifted, loaded and tested value) |
| opnd_b | input | 8 | Second operand (addend, subtrahend) |
| result | output | 8 | Combinational result of the selected operation |
| result_we | output | 1 | High when the operation writes its result back |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_v | output | 1 | Stored signed-overflow flag |
| flag_c | output | 1 | Stored carry (borrow for subtract and negate) flag |

## Verification
The assertions check several rules on every cycle:
- N follows the result's top bit after any flag write.
- Load keeps C and clears V.
- Hold and a disabled enable freeze all four flags.
- Add overflow matches the operand and result signs.
- Test and hold never raise the write strobe.

The exact result values, the borrow polarity on subtract and negate, the 0x80 negate corner, shift-right flag derivation and the reset clear are shown only by the bench's scenarios. These run against a behavioural model that uses signed integer arithmetic.

// File: rtl/alu8_pkg.sv
// Shared definitions for the byte ALU: operation codes, flag policies and
// flag bit positions inside the packed flag vector.
// Assumes the operation code is three bits wide and all eight values are used.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_NEG  = 3'd2,
        OP_ASR  = 3'd3,
        OP_CLR  = 3'd4,
        OP_LOAD = 3'd5,
        OP_TEST = 3'd6,
        OP_HOLD = 3'd7
    } alu_op_e;

    // What an operation does with one flag on a write
    typedef enum logic [1:0] {
        FA_KEEP = 2'd0,
        FA_CALC = 2'd1,
        FA_ZERO = 2'd2
    } flag_act_e;

    localparam int FLAG_COUNT = 4;
    localparam int FL_C = 0;
    localparam int FL_V = 1;
    localparam int FL_Z = 2;
    localparam int FL_N = 3;

    // Operations whose result is written back by the sequencer
    function automatic logic op_writes_result(alu_op_e op);
        return !(op == OP_TEST || op == OP_HOLD);
    endfunction

    // Policy of one flag under one operation
    function automatic flag_act_e flag_policy(alu_op_e op, int idx);
        flag_act_e act;
        case (op)
            OP_HOLD: act = FA_KEEP;
            OP_LOAD: begin
                if (idx == FL_V)      act = FA_ZERO;
                else if (idx == FL_C) act = FA_KEEP;
                else                  act = FA_CALC;
            end
            default: act = FA_CALC;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
// Combinational result and raw flag generator.
// Produces the result of the selected operation and the flag values that
// operation would compute. Masking against stored flags happens downstream.
// Assumes WIDTH >= 2. Subtract and negate report borrow in the carry bit.
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e                 op,
    input  logic [WIDTH-1:0]        a,
    input  logic [WIDTH-1:0]        b,
    output logic [WIDTH-1:0]        res,
    output logic [FLAG_COUNT-1:0]   calc
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] sum_w;
    logic [WIDTH:0] diff_w;
    logic [WIDTH:0] neg_w;
    logic           c_raw;
    logic           v_raw;

    // Extended-width sum, difference and negation; the top bit is carry or borrow
    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        diff_w = {1'b0, a} - {1'b0, b};
        neg_w  = {(WIDTH+1){1'b0}} - {1'b0, a};
    end

    // Result and the carry/overflow pair chosen by the operation
    always_comb begin
        res   = a;
        c_raw = 1'b0;
        v_raw = 1'b0;
        case (op)
            OP_ADD: begin
                res   = sum_w[MSB:0];
                c_raw = sum_w[WIDTH];
                v_raw = (a[MSB] == b[MSB]) && (sum_w[MSB] != a[MSB]);
            end
            OP_SUB: begin
                res   = diff_w[MSB:0];
                c_raw = diff_w[WIDTH];
                v_raw = (a[MSB] != b[MSB]) && (diff_w[MSB] != a[MSB]);
            end
            OP_NEG: begin
                res   = neg_w[MSB:0];
                c_raw = neg_w[WIDTH];
                v_raw = a[MSB] && neg_w[MSB];
            end
            OP_ASR: begin
                res   = {a[MSB], a[MSB:1]};
                c_raw = a[0];
                v_raw = a[MSB] ^ a[0];
            end
            OP_CLR: begin
                res   = '0;
            end
            default: begin
                res   = a;
            end
        endcase
    end

    // Pack the computed flags
    always_comb begin
        calc       = '0;
        calc[FL_N] = res[MSB];
        calc[FL_Z] = ~|res;
        calc[FL_V] = v_raw;
        calc[FL_C] = c_raw;
    end

endmodule

// File: rtl/alu8_flag_merge.sv
// Per-flag policy merge: each flag takes its computed value, zero, or the
// stored value, according to the policy the current operation assigns it.
// Assumes the stored flags come straight from the flag register.
module alu8_flag_merge
    import alu8_pkg::*;
(
    input  alu_op_e                 op,
    input  logic [FLAG_COUNT-1:0]   calc,
    input  logic [FLAG_COUNT-1:0]   cur,
    output logic [FLAG_COUNT-1:0]   nxt
);

    flag_act_e act [FLAG_COUNT];

    // Look up the policy of every flag for this operation
    always_comb begin
        for (int i = 0; i < FLAG_COUNT; i++) begin
            act[i] = flag_policy(op, i);
        end
    end

    // One selector per flag
    for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_sel
        always_comb begin
            case (act[g])
                FA_CALC: nxt[g] = calc[g];
                FA_ZERO: nxt[g] = 1'b0;
                default: nxt[g] = cur[g];
            endcase
        end
    end

endmodule

// File: rtl/alu8_flag_reg.sv
// Condition flag register with write enable and synchronous active-low reset.
// Assumes reset is sampled on the rising clock edge like any other input.
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [FLAG_COUNT-1:0]   d,
    output logic [FLAG_COUNT-1:0]   q
);

    // Capture the merged flags when enabled; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R12: an enabled write lands exactly the presented flags
    a_r12_capture: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

    // R12: without the enable the flags hold
    a_r12_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/alu8_nzvc.sv
// Top of the byte ALU with masked N/Z/V/C flags.
// The result path is combinational. The flags are registered and change only on
// an enabled clock edge. Assumes op_sel is stable around the rising edge.
module alu8_nzvc
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c
);

    localparam int MSB = WIDTH - 1;

    alu_op_e               op;
    logic [FLAG_COUNT-1:0] calc_flags;
    logic [FLAG_COUNT-1:0] cur_flags;
    logic [FLAG_COUNT-1:0] nxt_flags;

    // Decode the raw code into the operation type
    always_comb op = alu_op_e'(op_sel);

    alu8_arith #(.WIDTH(WIDTH)) arith_i (
        .op   (op),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (result),
        .calc (calc_flags)
    );

    alu8_flag_merge merge_i (
        .op   (op),
        .calc (calc_flags),
        .cur  (cur_flags),
        .nxt  (nxt_flags)
    );

    alu8_flag_reg freg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .d     (nxt_flags),
        .q     (cur_flags)
    );

    // Write-back strobe from the operation class
    always_comb result_we = op_writes_result(op);

    // Break the stored flags out to ports
    always_comb begin
        flag_n = cur_flags[FL_N];
        flag_z = cur_flags[FL_Z];
        flag_v = cur_flags[FL_V];
        flag_c = cur_flags[FL_C];
    end

    // R1: after a flag write, N equals the top bit of the result presented
    a_r1_n_follows_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel != 3'd7) |=> (flag_n == $past(result[MSB])));

    // R1: after a flag write, Z reflects an all-zero result
    a_r1_z_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel != 3'd7) |=> (flag_z == ($past(result) == '0)));

    // R3: add overflow follows operand and result signs
    a_r3_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 3'd0) |=>
        (flag_v == ($past(opnd_a[MSB] == opnd_b[MSB]) &&
                    $past(result[MSB] != opnd_a[MSB]))));

    // R9: load keeps carry and clears overflow
    a_r9_load_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && op_sel == 3'd5) |=> (flag_c == $past(flag_c) && !flag_v));

    // R10 and R11: test and hold never request a result write
    a_r10_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd6 || op_sel == 3'd7) |-> !result_we);

    // R11: hold freezes all four flags even with the enable high
    a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> $stable({flag_n, flag_z, flag_v, flag_c}));

endmodule

// File: tb/alu8_nzvc_tb_top.sv
// Self-checking bench: behavioural reference with signed integer arithmetic,
// compared every cycle on result, write strobe and stored flags.
module alu8_nzvc_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       flag_we;
    logic [2:0] op_sel;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic [7:0] result;
    logic       result_we;
    logic       flag_n, flag_z, flag_v, flag_c;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // model state
    bit mn = 0, mz = 0, mv = 0, mc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_nzvc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_we   (flag_we),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .result_we (result_we),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c)
    );

    function automatic string op_tag(int op);
        case (op)
            0: return "R2/R3 add";
            1: return "R4/R5 sub";
            2: return "R6 neg";
            3: return "R7 asr";
            4: return "R8 clr";
            5: return "R9 load";
            6: return "R10 test";
            default: return "R11 hold";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference: result, write strobe and next flags for one operation
    task automatic model(input int op, input int a, input int b,
                         output int r, output bit wr,
                         output bit nn, output bit nz, output bit nv, output bit nc);
        int sa, sb, t;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        nn = mn; nz = mz; nv = mv; nc = mc;
        wr = 1;
        r  = a;
        case (op)
            0: begin
                r = (a + b) % 256; nc = (a + b) > 255;
                t = sa + sb; nv = (t > 127) || (t < -128);
            end
            1: begin
                r = (a - b + 256) % 256; nc = b > a;
                t = sa - sb; nv = (t > 127) || (t < -128);
            end
            2: begin
                r = (256 - a) % 256; nc = a != 0;
                t = -sa; nv = t > 127;
            end
            3: begin
                r = (sa >>> 1) & 255; nc = a % 2;
            end
            4: begin r = 0; nc = 0; nv = 0; end
            5: begin r = a; nv = 0; end
            6: begin r = a; nc = 0; nv = 0; wr = 0; end
            default: begin r = a; wr = 0; end
        endcase
        if (op != 7) begin
            nn = r > 127;
            nz = r == 0;
        end
        if (op == 3) nv = nn ^ nc;
    endtask

    // One cycle: check stored flags, drive, check result, advance model at the edge
    task automatic step(int op, int a, int b, bit we, bit rst = 0);
        int r; bit wr, nn, nz, nv, nc;
        @(negedge clk);
        check("R12 flag N", flag_n, mn);
        check("R12 flag Z", flag_z, mz);
        check("R12 flag V", flag_v, mv);
        check("R12 flag C", flag_c, mc);
        op_sel = 3'(op); opnd_a = 8'(a); opnd_b = 8'(b);
        flag_we = we; rst_n = !rst;
        #1;
        model(op, a, b, r, wr, nn, nz, nv, nc);
        check({op_tag(op), " result"}, result, r);
        check({op_tag(op), " result_we"}, result_we, wr);
        @(posedge clk);
        if (rst) begin mn = 0; mz = 0; mv = 0; mc = 0; end
        else if (we) begin mn = nn; mz = nz; mv = nv; mc = nc; end
    endtask

    task automatic expect_flags(string tag, bit n, bit z, bit v, bit c);
        @(negedge clk);
        check({tag, " N"}, flag_n, n);
        check({tag, " Z"}, flag_z, z);
        check({tag, " V"}, flag_v, v);
        check({tag, " C"}, flag_c, c);
    endtask

    initial begin
        rst_n = 0; flag_we = 0; op_sel = 0; opnd_a = 0; opnd_b = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 reset flags", {flag_n, flag_z, flag_v, flag_c}, 0);
        rst_n = 1;

        // R2/R3 add 7A+52 -> CC, C=0 V=1 N=1
        step(0, 'h7A, 'h52, 1);
        expect_flags("R3 add 7A+52", 1, 0, 1, 0);
        step(0, 'h8A, 'hAC, 1);  // carry and overflow: 0x36
        step(0, 'hFF, 'h01, 1);  // R1 zero with carry
        expect_flags("R1 R2 add FF+01", 0, 1, 0, 1);
        // R4/R5 subtract
        step(1, 'h5C, 'h8A, 1);
        expect_flags("R5 sub 5C-8A", 1, 0, 1, 1);
        step(1, 'h7A, 'h5C, 1);
        step(1, 'h2C, 'h72, 1);
        step(1, 'h8A, 'h5C, 1);
        // R6 negate corners
        step(2, 'h80, 0, 1);
        expect_flags("R6 neg 80", 1, 0, 1, 1);
        step(2, 'h00, 0, 1);
        expect_flags("R6 neg 00", 0, 1, 0, 0);
        step(2, 'h01, 0, 1);
        // R7 shift right
        step(3, 'h81, 0, 1);
        expect_flags("R7 asr 81", 1, 0, 0, 1);
        step(3, 'h01, 0, 1);
        // R9 load keeps C set, clears V
        step(0, 'hC0, 'hC0, 1);   // C=1 V=0
        step(2, 'h80, 0, 1);      // V=1 C=1
        step(5, 'h00, 0, 1);
        expect_flags("R9 load keeps C", 0, 1, 0, 1);
        // R10 test
        step(6, 'h90, 0, 1);
        expect_flags("R10 test 90", 1, 0, 0, 0);
        // R11 hold with enable
        step(0, 'hFF, 'h01, 1);
        step(7, 'h00, 'h55, 1);
        expect_flags("R11 hold", 0, 1, 0, 1);
        // R8 clear
        step(4, 'hAB, 'hCD, 1);
        expect_flags("R8 clr", 0, 1, 0, 0);
        // R12 disabled write
        step(1, 'h00, 'h01, 0);
        expect_flags("R12 no enable", 0, 1, 0, 0);
        step(1, 'h00, 'h01, 1);
        step(0, 'h10, 'h10, 1, 1);   // R12 reset beats the enable
        expect_flags("R12 sync reset", 0, 0, 0, 0);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 7), $urandom_range(0, 255),
                 $urandom_range(0, 255), $urandom_range(0, 3) != 0);
        end
        step(7, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1;
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule